// File: doc/BRIEF.md
# Multiframe Reference Pulse Generator and Counter Aligner

The block makes a periodic reference pulse in the link clock domain and keeps a local multiframe counter. The pulse period and the counter length come from one configured multiframe length, counted in link clocks. The pulse is driven out of the block, and an incoming reference line (`sysref_i`) is sampled back in. A rising edge on that line can restart the counter, so that the counter wrap lines up with the multiframe boundary that the edge marks.

Software picks how edges are used. With continuous mode on, every rising edge restarts the counter. With continuous mode off, an armed single-detect restarts the counter on the first edge only and then disarms itself. Every rising edge that arrives after the counter was first aligned is also checked against the counter phase. An edge that falls off the boundary sets a sticky error flag. Software clears that flag by writing one to it.

Top module: `sysref_lmfc_sync`

## Requirements
- R1: During reset and in the first cycle after it, `sysref_o`, `lmfc_cnt_o`, `single_det_o` and `err_o` are 0. `lmfc_strobe_o` is also 0 whenever the effective length is above 1.
- R2: `sysref_o` is high for exactly one cycle in every L cycles, where L is the effective length. After reset it first goes high in the cycle after the L-th rising clock edge.
- R3: The effective length L is `mf_len_i` when that value is 2 or more, and 2 when it is 0 or 1.
- R4: If no restart happens, `lmfc_cnt_o` steps through 0, 1, …, L-1 and then back to 0. `lmfc_strobe_o` is high in exactly those cycles where `lmfc_cnt_o` ≥ L-1.
- R5: A rising edge is a cycle in which `sysref_i` is 1 and was 0 in the cycle before. A level that stays high counts as one edge only.
- R6: A rising edge that comes while continuous mode is on or single-detect is armed restarts the counter. The edge cycle counts as count 0, so `lmfc_cnt_o` is 1 in the next cycle.
- R7: A one-cycle pulse on `arm_i` makes `single_det_o` 1 from the next cycle on. The cycle after the first rising edge seen while armed, it returns to 0. If `arm_i` comes in the same cycle as an edge, the block stays armed.
- R8: With continuous mode off and single-detect not armed, rising edges leave the counter sequence unchanged.
- R9: Once the counter has been restarted at least once, any rising edge while `lmfc_cnt_o` ≠ 0 sets `err_o` in the next cycle, in any mode. The flag then stays set. The edge that first aligns the counter never sets the flag.
- R10: `err_clr_i` clears `err_o` in the next cycle. If a misaligned edge comes in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mf_len_i | input | MF_W | Multiframe length in link clocks |
| cont_en_i | input | 1 | Continuous mode: every edge restarts the counter |
| arm_i | input | 1 | Pulse that arms single detection |
| err_clr_i | input | 1 | Write-one-to-clear for the error flag |
| sysref_i | input | 1 | Incoming reference line (looped back or external) |
| sysref_o | output | 1 | Generated reference pulse |
| lmfc_strobe_o | output | 1 | Boundary strobe at the counter wrap |
| lmfc_cnt_o | output | MF_W | Multiframe counter value |
| single_det_o | output | 1 | Single-detect armed, reads 0 once an edge is seen |
| err_o | output | 1 | Sticky misalignment flag |

## Verification
The bench sends edges at off-boundary phases while nothing is armed, to check R8. A design that realigns anyway shifts the counter phase away from the model. It arms and sends an edge in the same cycle, which catches a design that lets the edge win and drops the arm. It also sends a misaligned edge together with a clear, which catches a design that lets the clear win. A level held high for many cycles shows whether the block counts a level as repeated edges. It also checks that the first aligning edge raises no error. Lengths of 0, 1 and 5 check the clamp and the wrap. A design that wraps at the wrong count makes the strobe or the pulse period drift from the model on every frame.

// File: rtl/sysref_lmfc_pkg.sv
package sysref_lmfc_pkg;
  localparam int unsigned MinMfLen = 2;

  typedef enum logic [1:0] {
    ACT_RUN,
    ACT_WRAP,
    ACT_RESTART
  } lmfc_act_e;
endpackage

// File: rtl/sysref_gen.sv
module sysref_gen #(
  parameter int unsigned MF_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [MF_W-1:0] len_i,
  output logic            sysref_o
);
  logic [MF_W-1:0] cnt_q;
  logic            wrap;

  assign wrap = (cnt_q >= len_i - MF_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sysref_o <= 1'b0;
    end else begin
      cnt_q    <= wrap ? '0 : cnt_q + MF_W'(1);
      sysref_o <= wrap;
    end
  end

  a_r2_one_cycle_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sysref_o |=> !sysref_o);
endmodule

// File: rtl/sysref_edge.sv
module sysref_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sysref_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sysref_i;
  end

  assign edge_o = sysref_i & ~prev_q;

  a_r5_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/lmfc_counter.sv
module lmfc_counter
  import sysref_lmfc_pkg::*;
#(
  parameter int unsigned MF_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [MF_W-1:0] len_i,
  input  logic            restart_i,
  output logic [MF_W-1:0] cnt_o,
  output logic            strobe_o
);
  lmfc_act_e act;

  assign strobe_o = (cnt_o >= len_i - MF_W'(1));

  always_comb begin
    if (restart_i)     act = ACT_RESTART;
    else if (strobe_o) act = ACT_WRAP;
    else               act = ACT_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else begin
      unique case (act)
        ACT_RESTART: cnt_o <= MF_W'(1); // edge cycle is count 0
        ACT_WRAP:    cnt_o <= '0;
        default:     cnt_o <= cnt_o + MF_W'(1);
      endcase
    end
  end

  a_r4_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && !restart_i) |=> (cnt_o == '0));
  a_r6_restart_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_o == MF_W'(1)));
endmodule

// File: rtl/align_ctrl.sv
module align_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  input  logic cnt_zero_i,
  input  logic cont_en_i,
  input  logic arm_i,
  input  logic err_clr_i,
  output logic restart_o,
  output logic single_det_o,
  output logic err_o
);
  logic aligned_q;
  logic misalign;

  assign restart_o = edge_i & (cont_en_i | single_det_o);
  assign misalign  = edge_i & aligned_q & ~cnt_zero_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aligned_q    <= 1'b0;
      single_det_o <= 1'b0;
      err_o        <= 1'b0;
    end else begin
      if (restart_o) aligned_q <= 1'b1;
      if (arm_i)       single_det_o <= 1'b1;
      else if (edge_i) single_det_o <= 1'b0;
      if (misalign)       err_o <= 1'b1;
      else if (err_clr_i) err_o <= 1'b0;
    end
  end

  a_r7_arm_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> single_det_o);
  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o);
  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && aligned_q && !cnt_zero_i) |=> err_o);
endmodule

// File: rtl/sysref_lmfc_sync.sv
module sysref_lmfc_sync
  import sysref_lmfc_pkg::*;
#(
  parameter int unsigned MF_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [MF_W-1:0] mf_len_i,
  input  logic            cont_en_i,
  input  logic            arm_i,
  input  logic            err_clr_i,
  input  logic            sysref_i,
  output logic            sysref_o,
  output logic            lmfc_strobe_o,
  output logic [MF_W-1:0] lmfc_cnt_o,
  output logic            single_det_o,
  output logic            err_o
);
  localparam logic [MF_W-1:0] MinLen = MF_W'(MinMfLen);

  logic [MF_W-1:0] eff_len;
  logic            edge_det;
  logic            restart;

  assign eff_len = (mf_len_i < MinLen) ? MinLen : mf_len_i;

  sysref_gen #(.MF_W(MF_W)) u_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .len_i    (eff_len),
    .sysref_o (sysref_o)
  );

  sysref_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sysref_i (sysref_i),
    .edge_o   (edge_det)
  );

  lmfc_counter #(.MF_W(MF_W)) u_lmfc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .len_i     (eff_len),
    .restart_i (restart),
    .cnt_o     (lmfc_cnt_o),
    .strobe_o  (lmfc_strobe_o)
  );

  align_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .edge_i       (edge_det),
    .cnt_zero_i   (lmfc_cnt_o == '0),
    .cont_en_i    (cont_en_i),
    .arm_i        (arm_i),
    .err_clr_i    (err_clr_i),
    .restart_o    (restart),
    .single_det_o (single_det_o),
    .err_o        (err_o)
  );
endmodule

// File: tb/sysref_lmfc_sync_tb_top.sv
`timescale 1ns/1ps
module sysref_lmfc_sync_tb_top;
  localparam int MF_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [MF_W-1:0] mf_len = 8'd8;
  logic cont_en = 1'b0, arm = 1'b0, err_clr = 1'b0;
  logic loop_en = 1'b1, sr_man = 1'b0, sr_loop = 1'b0;
  logic sysref_in;
  logic sysref_o, lmfc_strobe_o, single_det_o, err_o;
  logic [MF_W-1:0] lmfc_cnt_o;

  int checks = 0, failures = 0, cycles = 0;
  string phase = "R1";

  int m_gen, m_sr, m_cnt, m_prev, m_armed, m_aligned, m_err;

  always #2 clk = ~clk;

  assign sysref_in = loop_en ? sr_loop : sr_man;

  sysref_lmfc_sync #(.MF_W(MF_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mf_len_i(mf_len), .cont_en_i(cont_en),
    .arm_i(arm), .err_clr_i(err_clr), .sysref_i(sysref_in),
    .sysref_o(sysref_o), .lmfc_strobe_o(lmfc_strobe_o), .lmfc_cnt_o(lmfc_cnt_o),
    .single_det_o(single_det_o), .err_o(err_o)
  );

  function automatic int eff_len();
    return (int'(mf_len) < 2) ? 2 : int'(mf_len);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s (phase %s) t=%0t actual=%0d expected=%0d", req, phase, $time, act, exp);
    end
  endtask

  // behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    int len, edg, strobe, restart, mis, wrap;
    if (!rst_ni) begin
      m_gen = 0; m_sr = 0; m_cnt = 0; m_prev = 0;
      m_armed = 0; m_aligned = 0; m_err = 0;
    end else begin
      len     = eff_len();
      edg     = (sysref_in && !m_prev) ? 1 : 0;
      strobe  = (m_cnt >= len - 1) ? 1 : 0;
      restart = (edg && (cont_en || m_armed)) ? 1 : 0;
      mis     = (edg && m_aligned && m_cnt != 0) ? 1 : 0;
      m_cnt   = restart ? 1 : (strobe ? 0 : m_cnt + 1);
      if (restart) m_aligned = 1;
      if (arm) m_armed = 1; else if (edg) m_armed = 0;
      if (mis) m_err = 1; else if (err_clr) m_err = 0;
      m_prev  = int'(sysref_in);
      wrap    = (m_gen >= len - 1) ? 1 : 0;
      m_gen   = wrap ? 0 : m_gen + 1;
      m_sr    = wrap;
    end
  end

  always @(negedge clk) begin
    sr_loop <= sysref_o;
    cycles++;
    if (rst_ni) begin
      check("R2", int'(sysref_o), m_sr);
      check("R4", int'(lmfc_cnt_o), m_cnt);
      check("R4", int'(lmfc_strobe_o), (m_cnt >= eff_len() - 1) ? 1 : 0);
      check("R7", int'(single_det_o), m_armed);
      check("R9", int'(err_o), m_err);
    end
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic man_pulse();
    sr_man = 1'b1; tick(1); sr_man = 1'b0; tick(1);
  endtask

  initial begin
    tick(3);
    phase = "R1";
    check("R1", int'(sysref_o), 0);
    check("R1", int'(lmfc_cnt_o), 0);
    check("R1", int'(single_det_o), 0);
    check("R1", int'(err_o), 0);
    rst_ni = 1'b1;
    tick(1);
    check("R1", int'(lmfc_strobe_o), 0);
    check("R1", int'(err_o), 0);

    phase = "R2"; tick(40);

    // R8: unarmed, non-continuous edges at odd phases do not move the counter
    phase = "R8"; loop_en = 1'b0;
    tick(3); man_pulse(); tick(5); man_pulse(); tick(7);
    check("R8", int'(err_o), 0);

    // R7 and R6: arm, then an off-boundary edge realigns without error
    phase = "R7"; arm = 1'b1; tick(1); arm = 1'b0;
    check("R7", int'(single_det_o), 1);
    tick(2);
    phase = "R6"; sr_man = 1'b1; tick(1);
    check("R6", int'(lmfc_cnt_o), 1);
    check("R7", int'(single_det_o), 0);
    check("R9", int'(err_o), 0);
    sr_man = 1'b0; tick(4);

    // R9: aligned, unarmed; misaligned edge sets sticky flag
    phase = "R9"; man_pulse(); tick(10);
    check("R9", int'(err_o), 1);

    // R10: clear
    phase = "R10"; err_clr = 1'b1; tick(1); err_clr = 1'b0;
    check("R10", int'(err_o), 0);

    // R10: set wins over clear in the same cycle
    tick(3); sr_man = 1'b1; err_clr = 1'b1; tick(1);
    sr_man = 1'b0; err_clr = 1'b0;
    check("R10", int'(err_o), 1);
    err_clr = 1'b1; tick(1); err_clr = 1'b0;

    // R6: continuous mode with loopback, then steady alignment
    phase = "R6"; cont_en = 1'b1; loop_en = 1'b1; tick(20);
    err_clr = 1'b1; tick(1); err_clr = 1'b0;
    tick(50);
    check("R9", int'(err_o), 0);

    // R5: level held high is one edge
    phase = "R5"; loop_en = 1'b0; tick(3); sr_man = 1'b1; tick(25); sr_man = 1'b0; tick(6);
    cont_en = 1'b0;

    // R3: clamp of short lengths, and other lengths
    phase = "R3"; loop_en = 1'b1;
    mf_len = 8'd1; tick(20);
    mf_len = 8'd0; tick(20);
    phase = "R4"; mf_len = 8'd5; tick(30);

    // R7: arm in the same cycle as an edge keeps the block armed
    phase = "R7"; loop_en = 1'b0; tick(2);
    arm = 1'b1; sr_man = 1'b1; tick(1); arm = 1'b0; sr_man = 1'b0;
    check("R7", int'(single_det_o), 1);
    tick(3); man_pulse(); tick(10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule